// File: doc/BRIEF.md
# Triggered circular trace capture buffer

This block records packed trace words, delivered one per cycle by an upstream formatter, into an on-chip memory used as a ring. Capture runs while the enable bit of the control register is set. When a trigger arrives, a programmable post-trigger countdown starts. The countdown ends acquisition after a chosen number of further stored words, so the ring holds a window of history around the trigger event.

A debug master reaches the block through a simple word-addressed register port. It programs the write pointer, the countdown and the control bits, then starts capture. Afterwards it polls status and drains the memory through a data register that advances the read pointer on every read. A sticky Full flag tells the reader where the oldest valid word sits. When Full is set, the oldest word is at the write pointer. When Full is clear, the valid words occupy locations zero up to the write pointer minus one.

Top module: `trace_capture_buf`

## Requirements
- R1: Register word addresses are: 0 identification (constant ID_VALUE), 1 memory depth (constant DEPTH), 2 word width (constant DATA_W), 3 status, 4 memory data, 5 read pointer, 6 write pointer, 7 countdown, 8 control. Reads of addresses 9 to 15 return zero, and read data is combinational on the address.
- R2: When control bit 0 is set and acquisition is not complete, each cycle with `trc_valid` high stores `trc_data` at the write pointer, and the write pointer then advances modulo DEPTH. With capture off or complete, no word is stored and the write pointer holds.
- R3: Status bit 0 (Full) sets when a word is stored at location DEPTH-1 and stays set until the flags are cleared.
- R4: Status bit 1 (Triggered) sets when `trc_trigger` is high while capture is on and not complete. A trigger while capture is off has no effect.
- R5: Every stored word while triggered, the triggering word included, decrements the countdown, saturating at 0. The store that finds the countdown at 1 or 0 sets status bit 2 (complete), and no later word is stored.
- R6: Status bit 3 (formatter drained) reads 1 only while complete is set and `fmt_pending` is low.
- R7: A read of address 4 returns the word at the read pointer, zero-extended to 32 bits, and advances the read pointer modulo DEPTH.
- R8: Writes to addresses 5, 6 and 7 load the read pointer, write pointer and countdown. A register write wins over a same-cycle advance or decrement. A word stored in that cycle still lands at the old write pointer.
- R9: A write to address 8 stores bit 0 (enable) and bit 1 (demultiplexed port mode), which read back in the same positions. Writing bit 0 as 1 clears status bits 0 to 2, and this takes priority over a flag event in the same cycle. Writing 0 stops capture and leaves the flags unchanged.
- R10: After reset, both pointers, the countdown, the control bits and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_valid | input | 1 | A packed trace word is offered this cycle |
| trc_data | input | DATA_W | Packed trace word |
| trc_trigger | input | 1 | Trigger event, qualified by capture being on |
| fmt_pending | input | 1 | Formatter still holds a partly packed word |
| reg_rd | input | 1 | Register read strobe (side effect only on address 4) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
The collisions of interest come from a capture store and a register write in the same cycle. In these cycles a trace word arrives while software loads the write pointer or the countdown. A trigger can also coincide with a control write that sets the enable bit. The bench provokes each collision by driving `trc_valid` or `trc_trigger` in the same cycle as `reg_wr`. Its behavioural model applies the stated priority: software wins the pointer and the counter, the word still lands at the old location, and the restart clears the flag. Every register is read back afterwards and compared with the model.

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
  parameter int          DEPTH    = 64,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trc_trigger,
  input  logic              fmt_pending,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CNT_W-1:0]  tcnt;
  logic              en, demux, full, trig, done;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic cap_on, store, trig_now, step, drained;
  logic rd_data, wr_rp, wr_wp, wr_cnt, wr_ctl, restart;
  logic unused_wbits;

  assign cap_on   = en & ~done;
  assign store    = cap_on & trc_valid;
  assign trig_now = cap_on & trc_trigger;
  assign step     = store & (trig | trig_now);
  assign drained  = done & ~fmt_pending;

  assign rd_data  = reg_rd & (reg_addr == 4'd4);
  assign wr_rp    = reg_wr & (reg_addr == 4'd5);
  assign wr_wp    = reg_wr & (reg_addr == 4'd6);
  assign wr_cnt   = reg_wr & (reg_addr == 4'd7);
  assign wr_ctl   = reg_wr & (reg_addr == 4'd8);
  assign restart  = wr_ctl & reg_wdata[0];
  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (store) mem[wp] <= trc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      tcnt  <= '0;
      en    <= 1'b0;
      demux <= 1'b0;
      full  <= 1'b0;
      trig  <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (store)                 wp   <= bump(wp);
      if (wr_wp)                 wp   <= reg_wdata[AW-1:0];
      if (rd_data)               rp   <= bump(rp);
      if (wr_rp)                 rp   <= reg_wdata[AW-1:0];
      if (step)                  tcnt <= (tcnt == '0) ? '0 : tcnt - 1'b1;
      if (wr_cnt)                tcnt <= reg_wdata[CNT_W-1:0];
      if (store && wp == LAST)   full <= 1'b1;
      if (trig_now)              trig <= 1'b1;
      if (step && tcnt <= CNT_W'(1)) done <= 1'b1;
      if (wr_ctl) begin
        en    <= reg_wdata[0];
        demux <= reg_wdata[1];
      end
      if (restart) begin
        full <= 1'b0;
        trig <= 1'b0;
        done <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0: reg_rdata = ID_VALUE;
      4'd1: reg_rdata = 32'(DEPTH);
      4'd2: reg_rdata = 32'(DATA_W);
      4'd3: reg_rdata = {28'd0, drained, done, trig, full};
      4'd4: reg_rdata[DATA_W-1:0] = mem[rp];
      4'd5: reg_rdata[AW-1:0] = rp;
      4'd6: reg_rdata[AW-1:0] = wp;
      4'd7: reg_rdata[CNT_W-1:0] = tcnt;
      4'd8: reg_rdata[1:0] = {demux, en};
      default: reg_rdata = '0;
    endcase
  end

  a_r3_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full && !restart |=> full);

  a_r2_idle_wp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_wp |=> $stable(wp));

  a_r5_done_freezes_wp: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_wp |=> $stable(wp));

  a_r5_done_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trig);

  a_r7_rp_advances: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !wr_rp |=> rp == (($past(rp) == LAST) ? '0 : $past(rp) + 1'b1));

  a_r6_drained_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 4'd3 && reg_rdata[3] |-> reg_rdata[2] && !fmt_pending);
endmodule

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;
  localparam int D = 64;
  localparam logic [31:0] IDV = 32'h7C0B_0001;

  logic clk = 0, rst_n = 0;
  logic trc_valid = 0, trc_trigger = 0, fmt_pending = 0;
  logic [31:0] trc_data = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  always #2.5 clk = ~clk;

  trace_capture_buf dut_i (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_data(trc_data),
    .trc_trigger(trc_trigger), .fmt_pending(fmt_pending), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] mmem [D];
  int m_wp = 0, m_rp = 0, m_tc = 0, m_ctl = 0;
  bit m_full = 0, m_trig = 0, m_done = 0;
  int acyc = 0;
  int seed = 1;

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0: return IDV;
      1: return D;
      2: return 32;
      3: return {28'd0, m_done && !fmt_pending, m_done, m_trig, m_full};
      4: return mmem[m_rp];
      5: return m_rp;
      6: return m_wp;
      7: return m_tc;
      8: return m_ctl;
      default: return 0;
    endcase
  endfunction

  function automatic string dflt_tag(input int a);
    case (a)
      3: return "R4";
      4, 5: return "R7";
      6: return "R2";
      7: return "R5";
      8: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic upd(input bit v, input logic [31:0] d, input bit tg, input bit rd,
                     input bit wr, input int a, input logic [31:0] wd);
    bit on, st, tn, stp;
    int n_wp, n_rp, n_tc;
    bit n_full, n_trig, n_done;
    on = m_ctl[0] && !m_done;
    st = on && v;
    tn = on && tg;
    stp = st && (m_trig || tn);
    n_wp = m_wp; n_rp = m_rp; n_tc = m_tc;
    n_full = m_full; n_trig = m_trig; n_done = m_done;
    if (st) begin
      mmem[m_wp] = d;
      n_wp = (m_wp + 1) % D;
      if (m_wp == D - 1) n_full = 1;
    end
    if (tn) n_trig = 1;
    if (stp) begin
      if (m_tc <= 1) n_done = 1;
      n_tc = (m_tc == 0) ? 0 : m_tc - 1;
    end
    if (rd && a == 4) n_rp = (m_rp + 1) % D;
    if (wr) begin
      case (a)
        5: n_rp = wd % D;
        6: n_wp = wd % D;
        7: n_tc = wd & 32'hFFFF;
        8: begin
          m_ctl = wd & 3;
          if (wd[0]) begin n_full = 0; n_trig = 0; n_done = 0; end
        end
        default: ;
      endcase
    end
    m_wp = n_wp; m_rp = n_rp; m_tc = n_tc;
    m_full = n_full; m_trig = n_trig; m_done = n_done;
  endtask

  task automatic cyc(input bit v, input logic [31:0] d, input bit tg, input bit rd,
                     input bit wr, input int a, input logic [31:0] wd, input string tag);
    logic [31:0] e;
    string t;
    trc_valid = v; trc_data = d; trc_trigger = tg;
    reg_rd = rd; reg_wr = wr; reg_addr = 4'(a); reg_wdata = wd;
    #1;
    e = exp_read(a);
    t = (tag == "") ? dflt_tag(a) : tag;
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d: actual %h expected %h", t, a, reg_rdata, e);
    end
    @(posedge clk);
    upd(v, d, tg, rd, wr, a, wd);
    @(negedge clk);
  endtask

  task automatic look(input int a, input string tag);
    cyc(0, 0, 0, 0, 0, a, 0, tag);
  endtask

  task automatic wrreg(input int a, input logic [31:0] wd, input string tag);
    cyc(0, 0, 0, 0, 1, a, wd, tag);
  endtask

  task automatic push(input bit tg);
    seed = seed * 1103515245 + 12345;
    cyc(1, seed, tg, 0, 0, acyc % 9, 0, "");
    acyc++;
  endtask

  task automatic gap();
    look(acyc % 9, "");
    acyc++;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 4, 0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state and R1 map
    for (int a = 0; a < 16; a++) look(a, (a >= 3 && a <= 8) ? "R10" : "R1");

    // R5 countdown of 5 after trigger
    wrreg(7, 5, "R8");
    wrreg(6, 0, "R8");
    wrreg(8, 1, "R9");
    fmt_pending = 1;
    for (int i = 0; i < 10; i++) begin push(0); if (i % 3 == 2) gap(); end
    push(1);
    for (int i = 0; i < 8; i++) push(0);
    look(3, "R5");
    look(6, "R5");
    look(3, "R6");
    fmt_pending = 0;
    look(3, "R6");
    // R9 stop keeps flags, R2 no store while stopped
    wrreg(8, 0, "R9");
    look(3, "R9");
    for (int i = 0; i < 4; i++) push(1);
    look(6, "R2");
    look(3, "R4");
    // R7 drain from 0 (not full)
    wrreg(5, 0, "R8");
    drain(m_wp + 2);
    look(5, "R7");

    // R3 wrap and full, demux bit
    wrreg(7, 3, "R8");
    wrreg(6, 0, "R8");
    wrreg(8, 3, "R9");
    look(8, "R9");
    for (int i = 0; i < D + 6; i++) push(0);
    look(3, "R3");
    push(1);
    for (int i = 0; i < 4; i++) push(0);
    look(3, "R3");
    wrreg(5, m_wp, "R8");
    drain(D);

    // R4 trigger ignored when disabled
    wrreg(8, 1, "R9");
    look(3, "R9");
    wrreg(8, 0, "R9");
    cyc(1, 32'hDEAD_0001, 1, 0, 0, 3, 0, "R4");
    look(3, "R4");
    look(6, "R2");

    // collisions: store vs pointer write, trigger vs restart, decrement vs counter write
    wrreg(8, 1, "R9");
    push(0);
    cyc(1, 32'hC0DE_0002, 0, 0, 1, 6, 20, "R8");
    look(6, "R8");
    wrreg(5, 1, "R8");
    look(4, "R8");
    cyc(1, 32'hC0DE_0003, 1, 0, 1, 8, 1, "R9");
    look(3, "R9");
    wrreg(7, 9, "R8");
    push(1);
    cyc(1, 32'hC0DE_0004, 0, 0, 1, 7, 2, "R8");
    look(7, "R8");
    push(0);
    look(3, "R5");
    push(0);
    look(7, "R5");
    cyc(1, 32'h1234_5678, 0, 1, 1, 4, 7, "R8");
    look(5, "R8");

    // R5 counter zero: trigger word alone completes
    wrreg(7, 0, "R8");
    wrreg(8, 1, "R9");
    push(1);
    look(3, "R5");
    push(0);
    look(6, "R5");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule